// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block sits between the interrupt pins of a set of PCI slots and a sixteen-input interrupt controller. Each slot has four level-sensitive pins, INTA through INTD. The pins are first folded onto four shared interrupt lines, called line A to line D, by a rotation that depends on the slot's device number. This spreads the busy INTA pins of neighbouring slots across different lines. Several pins may land on the same line, and that line then carries their OR.

Each of the four lines has a byte-wide routing register, written through a byte-wide configuration port. The register names the interrupt request output that the line drives, or disables the line. Two bytes written through a separate I/O port hold one trigger-mode bit per request output; a set bit marks that request as level-triggered. The request outputs are purely combinational in the pins and in the routing registers, so the controller sees a routing change as soon as the register takes it.

Top module: `pirq_router`

## Requirements
- R1: After reset, all four routing registers read 0x80, both trigger-mode bytes read 0x00, `trig_level_o` is 0 and `irq_o` is 0 whatever the pin inputs are.
- R2: Pin p of slot s (bit s*4+p of `slot_int_i`, p = 0 for INTA through 3 for INTD) feeds line (p + d - 1) mod 4, where d = DEV_BASE + s is the slot's device number and lines A..D are numbered 0..3.
- R3: Each line is the OR of every pin input that maps onto it.
- R4: A line whose routing register holds a value below 16 drives `irq_o` bit equal to that value; a value of 16 or more disables the line, so it drives no output. With every line disabled, `irq_o` is 0.
- R5: When several lines route to the same request number, that `irq_o` bit is the OR of those lines.
- R6: A configuration write to offset 0x60+k (k = 0..3) loads routing register k for line k; reads at those offsets return it. Writes to any other offset change no routing register, and reads at any other offset return 0x00.
- R7: An I/O write to port 0x4D0 loads the trigger-mode byte for requests 0-7, and a write to 0x4D1 loads the byte for requests 8-15; both read back at the same ports. `trig_level_o[i]` equals the stored bit for request i, and a 1 means level-triggered.
- R8: A routing change shows on `irq_o` in the cycle that follows the clock edge that takes the write, with no added latency. The pin-to-request path is combinational.
- R9: I/O writes to ports other than 0x4D0 and 0x4D1 change neither trigger-mode byte, and I/O reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_int_i | input | NUM_SLOTS*4 | Pin levels, four per slot, INTA at the lowest bit of each group |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for `cfg_addr_i` |
| io_we_i | input | 1 | I/O byte write strobe |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data for `io_addr_i` |
| irq_o | output | 16 | Interrupt request levels |
| trig_level_o | output | 16 | Trigger mode per request, 1 = level |

## Verification
The assertions check on every cycle the properties that hold for any pin pattern. The reset values of the routing registers, the loading of both trigger-mode bytes, and the fact that stray configuration writes leave routing untouched are all checked this way. So are the upper bound on active requests set by the number of enabled lines, and a silent `irq_o` when every line is disabled. The rotation, the OR onto lines and onto shared requests, and the boundary between values 15 and 16 can only be shown by the bench's sweeps. The bench applies every pin pattern under several routing setups and compares each result with an arithmetic model.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NUM_SLOTS = 4,
  parameter int DEV_BASE  = 1,
  parameter logic [7:0]  ROUTE_OFS = 8'h60,
  parameter logic [15:0] TRIG_PORT = 16'h04D0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SLOTS*4-1:0] slot_int_i,
  input  logic                   cfg_we_i,
  input  logic [7:0]             cfg_addr_i,
  input  logic [7:0]             cfg_wdata_i,
  output logic [7:0]             cfg_rdata_o,
  input  logic                   io_we_i,
  input  logic [15:0]            io_addr_i,
  input  logic [7:0]             io_wdata_i,
  output logic [7:0]             io_rdata_o,
  output logic [15:0]            irq_o,
  output logic [15:0]            trig_level_o
);
  localparam int NLINES = 4;
  localparam int NIRQ   = 16;
  localparam logic [7:0] ROUTE_OFF = 8'h80;

  logic [NLINES-1:0][7:0] route_q;
  logic [1:0][7:0]        trig_q;
  logic [NLINES-1:0]      line;

  wire cfg_hit = cfg_addr_i[7:2] == ROUTE_OFS[7:2];
  wire io_hit  = io_addr_i[15:1] == TRIG_PORT[15:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= {NLINES{ROUTE_OFF}};
      trig_q  <= '0;
    end else begin
      if (cfg_we_i && cfg_hit) route_q[cfg_addr_i[1:0]] <= cfg_wdata_i;
      if (io_we_i && io_hit)   trig_q[io_addr_i[0]]     <= io_wdata_i;
    end
  end

  assign cfg_rdata_o  = cfg_hit ? route_q[cfg_addr_i[1:0]] : 8'h00;
  assign io_rdata_o   = io_hit ? trig_q[io_addr_i[0]] : 8'h00;
  assign trig_level_o = trig_q;

  always_comb begin
    line = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int p = 0; p < 4; p++)
        line[(p + DEV_BASE + s + 3) % NLINES] = line[(p + DEV_BASE + s + 3) % NLINES]
                                               | slot_int_i[s*4+p];
  end

  always_comb begin
    irq_o = '0;
    for (int k = 0; k < NLINES; k++)
      if (route_q[k] < 8'(NIRQ)) irq_o[route_q[k][3:0]] = irq_o[route_q[k][3:0]] | line[k];
  end

  logic [2:0] n_enabled;
  always_comb begin
    n_enabled = '0;
    for (int k = 0; k < NLINES; k++)
      if (route_q[k] < 8'(NIRQ)) n_enabled = n_enabled + 3'd1;
  end

  p_reset_route_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (route_q == {NLINES{ROUTE_OFF}} && trig_level_o == 16'h0000));

  p_route_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_addr_i == ROUTE_OFS) |=> cfg_rdata_o == $past(cfg_wdata_i) || $past(cfg_addr_i) != cfg_addr_i);

  p_route_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we_i || !cfg_hit) |=> $stable(route_q));

  p_trig_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we_i && io_addr_i == TRIG_PORT) |=> trig_level_o[7:0] == $past(io_wdata_i));

  p_trig_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we_i && io_addr_i == (TRIG_PORT | 16'h0001)) |=> trig_level_o[15:8] == $past(io_wdata_i));

  p_trig_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_we_i || !io_hit) |=> $stable(trig_level_o));

  p_irq_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_o) <= 32'(n_enabled));

  p_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (n_enabled == 3'd0) |-> irq_o == 16'h0000);
endmodule

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
  localparam int NS = 4;
  localparam int DB = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS*4-1:0] ints = '0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00, cfg_rdata;
  logic io_we = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0] io_wdata = 8'h00, io_rdata;
  logic [15:0] irq, trig;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pirq_router #(.NUM_SLOTS(NS), .DEV_BASE(DB)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_int_i(ints),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .io_we_i(io_we), .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .irq_o(irq), .trig_level_o(trig));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_we = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_we = 1'b0;
  endtask

  function automatic logic [15:0] model(input logic [15:0] pins, input logic [31:0] rt);
    logic [3:0] ln;
    logic [15:0] o;
    ln = '0;
    o = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++)
        if (pins[s*4+p]) ln[(p + DB + s + 3) % 4] = 1'b1;
    for (int k = 0; k < 4; k++)
      if (rt[k*8 +: 8] < 8'd16 && ln[k]) o[rt[k*8 +: 4]] = 1'b1;
    return o;
  endfunction

  task automatic set_routes(input logic [31:0] rt);
    for (int k = 0; k < 4; k++) cfg_wr(8'h60 + 8'(k), rt[k*8 +: 8]);
  endtask

  task automatic sweep(input string req, input logic [31:0] rt);
    set_routes(rt);
    for (int p = 0; p < 65536; p++) begin
      ints = 16'(p);
      #1;
      chk(req, {16'h0, irq}, {16'h0, model(16'(p), rt)});
    end
    ints = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ints = 16'hFFFF;
    #1;
    chk("R1 irq after reset", {16'h0, irq}, 32'h0);
    chk("R1 trig after reset", {16'h0, trig}, 32'h0);
    ints = '0;
    for (int k = 0; k < 4; k++) begin
      cfg_addr = 8'h60 + 8'(k); #1;
      chk("R1 route reset", {24'h0, cfg_rdata}, 32'h80);
    end
    io_addr = 16'h04D0; #1; chk("R1 trig byte lo", {24'h0, io_rdata}, 32'h0);
    io_addr = 16'h04D1; #1; chk("R1 trig byte hi", {24'h0, io_rdata}, 32'h0);

    set_routes(32'h04050607);
    for (int k = 0; k < 4; k++) begin
      cfg_addr = 8'h60 + 8'(k); #1;
      chk("R6 route readback", {24'h0, cfg_rdata}, 32'h07 - 32'(k));
    end
    // single pins: rotation line (p + dev - 1) mod 4 drives irq 7 - line
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++) begin
        ints = 16'(1) << (s*4+p); #1;
        chk("R2 rotation", {16'h0, irq}, 32'h1 << (7 - ((p + DB + s + 3) % 4)));
      end
    ints = '0;

    sweep("R3 disjoint routing", 32'h04050607);
    sweep("R5 paired sharing 10/11", 32'h0B0A0B0A);
    sweep("R4 limits 0F/10/00/FF", 32'hFF00100F);
    sweep("R5 all lines on irq 3", 32'h03030303);

    set_routes(32'h80808080);
    ints = 16'hFFFF; #1;
    chk("R4 all disabled", {16'h0, irq}, 32'h0);

    // R8: routing change visible the cycle after the write edge
    ints = 16'h0001;
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 8'h60; cfg_wdata = 8'h0E;
    #1; chk("R8 before edge", {16'h0, irq}, 32'h0);
    @(negedge clk); cfg_we = 1'b0;
    #1; chk("R8 after edge", {16'h0, irq}, 32'h4000);
    ints = '0; #1;
    chk("R8 pin release", {16'h0, irq}, 32'h0);

    // R6: stray config offsets
    cfg_wr(8'h64, 8'h05);
    cfg_wr(8'h5F, 8'h05);
    cfg_addr = 8'h64; #1; chk("R6 stray read", {24'h0, cfg_rdata}, 32'h0);
    cfg_addr = 8'h60; #1; chk("R6 route kept", {24'h0, cfg_rdata}, 32'h0E);
    cfg_addr = 8'h61; #1; chk("R6 route kept b", {24'h0, cfg_rdata}, 32'h80);
    ints = 16'hFFFF; #1;
    chk("R6 irq after stray", {16'h0, irq}, 32'h4000);
    ints = '0;

    // R7 trigger bytes
    io_wr(16'h04D1, 8'h0C);
    io_wr(16'h04D0, 8'hA5);
    chk("R7 trig vector", {16'h0, trig}, 32'h0CA5);
    io_addr = 16'h04D0; #1; chk("R7 read lo", {24'h0, io_rdata}, 32'hA5);
    io_addr = 16'h04D1; #1; chk("R7 read hi", {24'h0, io_rdata}, 32'h0C);

    // R9 other ports
    io_wr(16'h04D2, 8'hFF);
    io_wr(16'h14D0, 8'hFF);
    io_wr(16'h04CF, 8'hFF);
    chk("R9 trig unchanged", {16'h0, trig}, 32'h0CA5);
    io_addr = 16'h04D2; #1; chk("R9 stray read", {24'h0, io_rdata}, 32'h0);
    io_addr = 16'h04D0; #1; chk("R9 lo kept", {24'h0, io_rdata}, 32'hA5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule